// File: doc/BRIEF.md
# Flash Sector Protection Gatekeeper

This block sits between a flash command decoder and the flash array model, and decides which program and erase requests reach the array. It keeps one protection bit for each sector. A synchronous configuration port sets and clears these bits. A request to a protected sector is refused with a one-cycle deny pulse. A request to an unprotected sector is passed on to the array as a one-cycle request pulse.

Two status flags change this gating. The temporary-override flag stands for the raised-voltage condition on the reset pin. While it is high, protected sectors accept program and erase, and the stored bits are not changed. When it drops, the earlier protection applies again. The supply-lockout flag stands for a supply below the write threshold. While it is high, every write and configuration cycle is dropped, nothing is queued, and any array operation still running is aborted.

A verify read returns the protection state of a sector on an 8-bit identifier bus. The read takes the sector on the high address bits and an identifier address on the low bits: bit 6 low, bit 1 high and bit 0 low. Other low bits are ignored. The read needs no high-voltage condition.

Top module: `sector_guard`

## Requirements
- R1: After reset, arr_req, deny and arr_abort are 0, id_data is 00h, and every sector reads back as unprotected.
- R2: When idle, with lockout low, a request (wr_req=1) to a sector whose protection bit is 0 gives arr_req=1 for exactly one cycle, on the cycle after the request. arr_sector and arr_erase carry the request's sector and kind.
- R3: When idle, with lockout low and override low, a request to a protected sector gives deny=1 for one cycle after the request, and arr_req stays 0.
- R4: While tmp_unprot=1, a request to a protected sector is granted as in R2, with no deny.
- R5: After tmp_unprot returns to 0, a sector that was protected before is refused again, and its verify read still returns 01h.
- R6: With id_rd=1 and id_addr_lo bit 6=0, bit 1=1 and bit 0=0, id_data on the next cycle is 01h when sector id_sector is protected, and 00h when it is not.
- R7: A verify read with any other combination of bits 6, 1 and 0 returns 00h. With id_rd=0, id_data is 00h.
- R8: While low_vcc=1, requests produce neither arr_req nor deny. After low_vcc clears, no refused request is replayed.
- R9: If low_vcc=1 while an array operation is in progress, arr_abort pulses on the next cycle and the operation ends. The next request after lockout is then accepted without waiting for arr_done.
- R10: cfg_en=1 writes cfg_set into the protection bit of cfg_sector. A configuration cycle with low_vcc=1 has no effect.
- R11: A request that arrives between a grant and the matching arr_done produces neither arr_req nor deny.
- R12: A request and a configuration write to the same sector in the same cycle: the request is judged on the protection bit as it was before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Decoded program/erase request |
| wr_erase | input | 1 | 1 = erase, 0 = program |
| wr_sector | input | SEC_W | Target sector of request |
| arr_done | input | 1 | Array reports the running operation finished |
| cfg_en | input | 1 | Protection configuration write |
| cfg_set | input | 1 | Value written to the protection bit |
| cfg_sector | input | SEC_W | Sector being configured |
| id_rd | input | 1 | Verify read request |
| id_sector | input | SEC_W | Sector on the high address bits |
| id_addr_lo | input | LO_W | Low address bits of the verify read |
| tmp_unprot | input | 1 | Temporary-override flag |
| low_vcc | input | 1 | Supply-lockout flag |
| arr_req | output | 1 | One-cycle grant to the array |
| arr_erase | output | 1 | Kind of granted operation |
| arr_sector | output | SEC_W | Sector of granted operation |
| deny | output | 1 | One-cycle refusal pulse |
| arr_abort | output | 1 | One-cycle abort of running operation |
| id_data | output | 8 | Identifier read data |

## Verification
A configuration write and a request can hit the same sector in the same cycle. So can a supply lockout and a request or configuration write. The bench drives these collisions on purpose in directed steps, and random stimulus raises them often. The protection bits are drawn from few sectors, and the flags toggle with high probability. Each result is compared with a bench model. The model judges a request on the old protection bit and applies lockout before any grant or configuration update.

// File: rtl/sg_pkg.sv
// Package: shared constants for the sector gatekeeper.
// Assumes: identifier address bits sit at fixed positions of the low address.
package sg_pkg;
    localparam int ID_BIT_A6 = 6;
    localparam int ID_BIT_A1 = 1;
    localparam int ID_BIT_A0 = 0;
    localparam logic [7:0] CODE_PROT   = 8'h01;
    localparam logic [7:0] CODE_UNPROT = 8'h00;

    typedef enum logic [1:0] {
        GATE_IDLE   = 2'd0,
        GATE_GRANT  = 2'd1,
        GATE_REFUSE = 2'd2,
        GATE_DROP   = 2'd3
    } gate_verdict_e;
endpackage

// File: rtl/sg_prot_store.sv
// Module: per-sector protection bit storage.
// Does: holds one bit per sector and updates it from the configuration port.
// Assumes: configuration is blocked while the supply-lockout flag is high.
module sg_prot_store #(
    parameter int SEC_W = 4,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_set,
    input  logic [SEC_W-1:0] cfg_sector,
    input  logic             low_vcc,
    output logic [NSEC-1:0]  prot
);
    logic cfg_ok;

    // Configuration accepted only outside lockout.
    always_comb cfg_ok = cfg_en && !low_vcc;

    for (genvar s = 0; s < NSEC; s++) begin : g_bit
        // Per-sector bit register, written when its sector is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prot[s] <= 1'b0;
            else if (cfg_ok && (cfg_sector == SEC_W'(s)))
                prot[s] <= cfg_set;
        end
    end

    assert_lockout_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        low_vcc |=> $stable(prot));
endmodule

// File: rtl/sg_write_gate.sv
// Module: program/erase gating with operation tracking and abort.
// Does: grants or refuses a request from the sector's effective protection,
//       tracks one running array operation and aborts it on supply lockout.
// Assumes: only one array operation runs at a time; arr_done ends it.
module sg_write_gate
    import sg_pkg::*;
#(
    parameter int SEC_W = 4,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             wr_erase,
    input  logic [SEC_W-1:0] wr_sector,
    input  logic             arr_done,
    input  logic [NSEC-1:0]  prot,
    input  logic             tmp_unprot,
    input  logic             low_vcc,
    output logic             arr_req,
    output logic             arr_erase,
    output logic [SEC_W-1:0] arr_sector,
    output logic             deny,
    output logic             arr_abort
);
    gate_verdict_e verdict;
    logic          op_active;
    logic          locked;

    // Effective lock: stored bit, overridden while the temporary flag is high.
    always_comb locked = prot[wr_sector] && !tmp_unprot;

    // Verdict for the current request cycle.
    always_comb begin
        if (!wr_req)
            verdict = GATE_IDLE;
        else if (low_vcc || op_active)
            verdict = GATE_DROP;
        else if (locked)
            verdict = GATE_REFUSE;
        else
            verdict = GATE_GRANT;
    end

    // Output pulses and the captured operation fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_req    <= 1'b0;
            deny       <= 1'b0;
            arr_abort  <= 1'b0;
            arr_erase  <= 1'b0;
            arr_sector <= '0;
        end else begin
            arr_req   <= (verdict == GATE_GRANT);
            deny      <= (verdict == GATE_REFUSE);
            arr_abort <= low_vcc && op_active;
            if (verdict == GATE_GRANT) begin
                arr_erase  <= wr_erase;
                arr_sector <= wr_sector;
            end
        end
    end

    // Running-operation flag: lockout clears, grant sets, done clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_active <= 1'b0;
        else if (low_vcc)
            op_active <= 1'b0;
        else if (verdict == GATE_GRANT)
            op_active <= 1'b1;
        else if (arr_done)
            op_active <= 1'b0;
    end

    assert_grant_deny_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_req && deny));
    assert_deny_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> $past(wr_req));
    assert_lockout_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_vcc |=> (!arr_req && !deny));
    assert_abort_on_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_vcc && op_active) |=> (arr_abort && !op_active));
    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_active |=> !arr_req);
endmodule

// File: rtl/sg_id_read.sv
// Module: protection-verify identifier read path.
// Does: decodes the identifier address and returns the sector's code.
// Assumes: bits 6, 1, 0 of the low address select the verify code.
module sg_id_read
    import sg_pkg::*;
#(
    parameter int SEC_W = 4,
    parameter int LO_W  = 8,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_rd,
    input  logic [SEC_W-1:0] id_sector,
    input  logic [LO_W-1:0]  id_addr_lo,
    input  logic [NSEC-1:0]  prot,
    output logic [7:0]       id_data
);
    logic code_hit;

    // Identifier address match: bit 6 low, bit 1 high, bit 0 low.
    always_comb code_hit = !id_addr_lo[ID_BIT_A6] && id_addr_lo[ID_BIT_A1]
                           && !id_addr_lo[ID_BIT_A0];

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_data <= CODE_UNPROT;
        else if (id_rd && code_hit)
            id_data <= prot[id_sector] ? CODE_PROT : CODE_UNPROT;
        else
            id_data <= CODE_UNPROT;
    end

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rd || !code_hit) |=> (id_data == 8'h00));
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_data == 8'h00) || (id_data == 8'h01));
endmodule

// File: rtl/sector_guard.sv
// Module: top of the flash sector protection gatekeeper.
// Does: ties protection storage, write gating and the verify read path.
// Assumes: inputs are synchronous to clk; LO_W is at least 7.
module sector_guard #(
    parameter int SEC_W = 4,
    parameter int LO_W  = 8,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             wr_erase,
    input  logic [SEC_W-1:0] wr_sector,
    input  logic             arr_done,
    input  logic             cfg_en,
    input  logic             cfg_set,
    input  logic [SEC_W-1:0] cfg_sector,
    input  logic             id_rd,
    input  logic [SEC_W-1:0] id_sector,
    input  logic [LO_W-1:0]  id_addr_lo,
    input  logic             tmp_unprot,
    input  logic             low_vcc,
    output logic             arr_req,
    output logic             arr_erase,
    output logic [SEC_W-1:0] arr_sector,
    output logic             deny,
    output logic             arr_abort,
    output logic [7:0]       id_data
);
    logic [NSEC-1:0] prot;

    sg_prot_store #(.SEC_W(SEC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_set(cfg_set),
        .cfg_sector(cfg_sector), .low_vcc(low_vcc), .prot(prot)
    );

    sg_write_gate #(.SEC_W(SEC_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_erase(wr_erase),
        .wr_sector(wr_sector), .arr_done(arr_done), .prot(prot),
        .tmp_unprot(tmp_unprot), .low_vcc(low_vcc), .arr_req(arr_req),
        .arr_erase(arr_erase), .arr_sector(arr_sector), .deny(deny),
        .arr_abort(arr_abort)
    );

    sg_id_read #(.SEC_W(SEC_W), .LO_W(LO_W)) u_id (
        .clk(clk), .rst_n(rst_n), .id_rd(id_rd), .id_sector(id_sector),
        .id_addr_lo(id_addr_lo), .prot(prot), .id_data(id_data)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!arr_req && !deny && !arr_abort && id_data == 8'h00));
endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;
    localparam int SEC_W = 4;
    localparam int LO_W  = 8;
    localparam int NSEC  = 1 << SEC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 0, wr_erase = 0, arr_done = 0, cfg_en = 0, cfg_set = 0;
    logic id_rd = 0, tmp_unprot = 0, low_vcc = 0;
    logic [SEC_W-1:0] wr_sector = '0, cfg_sector = '0, id_sector = '0;
    logic [LO_W-1:0]  id_addr_lo = '0;
    logic arr_req, arr_erase, deny, arr_abort;
    logic [SEC_W-1:0] arr_sector;
    logic [7:0] id_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;
    bit m_prot [NSEC];
    bit m_op = 0;

    always #4 clk = ~clk;

    sector_guard #(.SEC_W(SEC_W), .LO_W(LO_W)) i_sector_guard (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_erase(wr_erase),
        .wr_sector(wr_sector), .arr_done(arr_done), .cfg_en(cfg_en),
        .cfg_set(cfg_set), .cfg_sector(cfg_sector), .id_rd(id_rd),
        .id_sector(id_sector), .id_addr_lo(id_addr_lo), .tmp_unprot(tmp_unprot),
        .low_vcc(low_vcc), .arr_req(arr_req), .arr_erase(arr_erase),
        .arr_sector(arr_sector), .deny(deny), .arr_abort(arr_abort),
        .id_data(id_data)
    );

    function automatic bit id_match(logic [LO_W-1:0] a);
        return !a[6] && a[1] && !a[0];
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic quiet();
        wr_req = 0; arr_done = 0; cfg_en = 0; id_rd = 0;
    endtask

    // One clock: inputs already set; compute expected, clock, compare, update model.
    task automatic step(string tag);
        bit live, e_req, e_deny, e_abort;
        int e_id;
        string t;
        live    = wr_req && !low_vcc && !m_op;
        e_req   = live && (!m_prot[wr_sector] || tmp_unprot);
        e_deny  = live && m_prot[wr_sector] && !tmp_unprot;
        e_abort = low_vcc && m_op;
        e_id    = (id_rd && id_match(id_addr_lo)) ? int'(m_prot[id_sector]) : 0;
        if (tag != "") t = tag;
        else if (low_vcc) t = "R8";
        else if (m_op) t = "R11";
        else if (m_prot[wr_sector]) t = tmp_unprot ? "R4" : "R3";
        else t = "R2";
        @(posedge clk);
        #2;
        check(t, "arr_req", int'(arr_req), int'(e_req));
        check(t, "deny", int'(deny), int'(e_deny));
        check((tag != "") ? tag : "R9", "arr_abort", int'(arr_abort), int'(e_abort));
        check((tag != "") ? tag : "R6", "id_data", int'(id_data), e_id);
        if (e_req) begin
            check(t, "arr_sector", int'(arr_sector), int'(wr_sector));
            check(t, "arr_erase", int'(arr_erase), int'(wr_erase));
        end
        if (low_vcc) m_op = 0;
        else if (e_req) m_op = 1;
        else if (arr_done) m_op = 0;
        if (cfg_en && !low_vcc) m_prot[cfg_sector] = cfg_set;
        @(negedge clk);
    endtask

    task automatic do_read(logic [SEC_W-1:0] s, string tag);
        quiet(); id_rd = 1; id_sector = s; id_addr_lo = 8'h02; step(tag); quiet();
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=0 exp=1");
        if (!done_flag) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEC; i++) m_prot[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1: reset state
        check("R1", "arr_req", int'(arr_req), 0);
        check("R1", "deny", int'(deny), 0);
        check("R1", "arr_abort", int'(arr_abort), 0);
        check("R1", "id_data", int'(id_data), 0);
        @(negedge clk);
        for (int s = 0; s < NSEC; s++) do_read(SEC_W'(s), "R1");

        // R10: protect sector 3, then verify read returns 01h (R6)
        quiet(); cfg_en = 1; cfg_set = 1; cfg_sector = 3; step("R10");
        do_read(3, "R6");
        do_read(4, "R6");
        // R7: non-identifier low address combinations
        quiet(); id_rd = 1; id_sector = 3; id_addr_lo = 8'h03; step("R7");
        quiet(); id_rd = 1; id_sector = 3; id_addr_lo = 8'h42; step("R7");
        quiet(); id_rd = 1; id_sector = 3; id_addr_lo = 8'h00; step("R7");
        quiet(); id_rd = 1; id_sector = 3; id_addr_lo = 8'hBE; step("R6");

        // R3: refusal of protected sector
        quiet(); wr_req = 1; wr_sector = 3; step("R3");
        // R2: grant, then done
        quiet(); wr_req = 1; wr_sector = 5; wr_erase = 1; step("R2");
        // R11: request while busy is dropped
        quiet(); wr_req = 1; wr_sector = 6; step("R11");
        quiet(); arr_done = 1; step("R11");
        // R12: same-cycle clear of sector 3 with request to 3 -> still refused
        quiet(); wr_req = 1; wr_sector = 3; cfg_en = 1; cfg_set = 0; cfg_sector = 3; step("R12");
        quiet(); wr_req = 1; wr_sector = 3; wr_erase = 0; step("R12");
        quiet(); arr_done = 1; step("R12");
        // R12: same-cycle set of sector 7 with request to 7 -> granted
        quiet(); wr_req = 1; wr_sector = 7; cfg_en = 1; cfg_set = 1; cfg_sector = 7; step("R12");
        quiet(); arr_done = 1; step("R12");

        // R4: temporary override grants protected sector 7
        quiet(); tmp_unprot = 1; wr_req = 1; wr_sector = 7; step("R4");
        quiet(); arr_done = 1; step("R4");
        do_read(7, "R4");
        // R5: override removed -> refused again, bit still reads 01h
        tmp_unprot = 0;
        quiet(); wr_req = 1; wr_sector = 7; step("R5");
        do_read(7, "R5");

        // R8: lockout drops requests; none replayed after
        quiet(); low_vcc = 1; wr_req = 1; wr_sector = 2; step("R8");
        quiet(); wr_req = 1; wr_sector = 7; step("R8");
        low_vcc = 0;
        quiet(); step("R8");
        quiet(); step("R8");
        // R10: configuration blocked during lockout
        quiet(); low_vcc = 1; cfg_en = 1; cfg_set = 1; cfg_sector = 9; step("R10");
        low_vcc = 0;
        do_read(9, "R10");
        // R9: lockout aborts running op; next request accepted without done
        quiet(); wr_req = 1; wr_sector = 1; step("R9");
        quiet(); low_vcc = 1; step("R9");
        low_vcc = 0;
        quiet(); wr_req = 1; wr_sector = 2; step("R9");
        quiet(); arr_done = 1; step("R9");

        // Constrained random with fixed seed
        void'($urandom(32'h5EC7));
        for (int k = 0; k < 3000; k++) begin
            wr_req     = ($urandom_range(0, 99) < 50);
            wr_erase   = $urandom_range(0, 1);
            wr_sector  = SEC_W'($urandom_range(0, 5));
            arr_done   = ($urandom_range(0, 99) < 30);
            cfg_en     = ($urandom_range(0, 99) < 25);
            cfg_set    = $urandom_range(0, 1);
            cfg_sector = SEC_W'($urandom_range(0, 5));
            id_rd      = $urandom_range(0, 1);
            id_sector  = SEC_W'($urandom_range(0, 5));
            id_addr_lo = ($urandom_range(0, 1) == 1) ? LO_W'(8'h02 | ($urandom_range(0, 15) << 2) & 8'hBC)
                                                      : LO_W'($urandom_range(0, 255));
            if ($urandom_range(0, 99) < 10) tmp_unprot = ~tmp_unprot;
            if ($urandom_range(0, 99) < 8)  low_vcc = ~low_vcc;
            step("");
        end
        quiet(); low_vcc = 0; tmp_unprot = 0;

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule